// File: doc/BRIEF.md
# Auto-Reload PWM Timer with Forced Overflow

This block is a 12-bit up-counter that runs between a programmable start value and its terminal count of all ones. On every overflow it wraps back to the start value held in a reload register. On the same overflow it copies a buffered duty value into the active compare register. The PWM output is high from the first count after a reload until the counter reaches the active duty value.

Software reaches the block through a single-cycle register write port. A selector picks the reload register, the duty preload register or the force command. The counter only advances on cycles where a count-enable tick is high, so a divided clock can drive the period.

Writing the force command puts the counter straight at its terminal count, so the next tick produces the overflow at once. That overflow reloads the counter and commits the pending duty value without waiting out the rest of the period. A status output shows the force request until the overflow that serves it. Reset is asynchronous active-low and is released synchronously inside the block.

Top module: `art_pwm_timer`

## Requirements
- R1: After reset the count is 0, the PWM output is low, the overflow pulse is low, the force status is clear, and the reload and both duty registers hold 0.
- R2: The count rises by exactly one on each clock edge where `tick` is high and no overflow or force applies. With `tick` low and no force, it keeps its value.
- R3: When `tick` is high while the count is 0xFFF, the overflow occurs: on the next edge the count takes the reload register value.
- R4: A write with `wr_sel` = 2 (force) puts the count at 0xFFF on the next edge, whether `tick` is high or not, and sets the force status. The status stays set until an overflow, and `wr_data` is ignored for this write.
- R5: The force status clears on the edge of the overflow that follows a force. A force write made in the same cycle as an overflow is satisfied by that overflow: the count takes the reload value and the status reads clear.
- R6: A write with `wr_sel` = 1 stores the duty value in a preload register only. The value already in the preload becomes the active duty at an overflow, natural or forced. A duty write in the same cycle as an overflow takes effect at the following overflow.
- R7: The PWM output is high exactly when the count is greater than the period start value and less than the active duty. A duty at or below the period start holds the output low for the whole period.
- R8: A write with `wr_sel` = 0 changes the reload register. That value becomes the counter's target and the PWM period start only at the next overflow; the period start is 0 before the first overflow.
- R9: `ovf` is high for exactly the one clock cycle in which the count wraps from 0xFFF, and low otherwise. `wr_sel` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for the current cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload, 1 duty preload, 2 force, 3 none |
| wr_data | input | 12 | Write data |
| cnt | output | 12 | Current count |
| pwm | output | 1 | PWM output |
| ovf | output | 1 | Overflow pulse, high in the wrapping cycle |
| force_pend | output | 1 | Force request not yet served by an overflow |

## Verification
A wrong count, a lost reload or a stale period start shows on `cnt` and `pwm` within one clock of the edge where it occurs. A missed duty commit changes the PWM falling edge in the very next period. A force bit that never clears, or one that sets during a coincident overflow, shows on `force_pend` one cycle after the overflow. The sweeps cover reload values near the terminal count, every duty across and beyond the period, and sparse tick patterns with forces injected mid-period. The counter is compared against an arithmetic model every cycle.

// File: rtl/art_pkg.sv
package art_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_FORCE  = 2'd2,
    SEL_NONE   = 2'd3
  } art_sel_e;
endpackage

// File: rtl/art_rst_sync.sv
module art_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/art_counter.sv
module art_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_req,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] base_nxt,
  output logic             wrap,
  output logic             pend
);
  localparam logic [CNT_W-1:0] TERMINAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, base_q;
  logic             pend_q, pend_d;
  logic             cnt_en, base_en, pend_en;

  assign wrap = tick && (cnt_q == TERMINAL);

  always_comb begin
    cnt_nxt  = cnt_q;
    base_nxt = base_q;
    pend_d   = pend_q;
    if (wrap) begin
      cnt_nxt  = reload;
      base_nxt = reload;
      pend_d   = 1'b0;
    end else if (force_req) begin
      cnt_nxt = TERMINAL;
      pend_d  = 1'b1;
    end else if (tick) begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  assign cnt_en  = wrap || force_req || tick;
  assign base_en = wrap;
  assign pend_en = wrap || force_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_nxt;
      if (base_en) base_q <= base_nxt;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign cnt  = cnt_q;
  assign base = base_q;
  assign pend = pend_q;

  // R3: a wrap lands on the reload value
  a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(reload));
  // R4: force without coincident wrap lands on terminal count
  a_r4_force_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !wrap) |=> (cnt_q == TERMINAL) && pend_q);
  // R5: any wrap leaves the force status clear
  a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !pend_q);
  // R2: idle cycles keep the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_req) |=> $stable(cnt_q));
  // R9: no back-to-back wrap unless reload is terminal
  a_r9_single_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && reload != TERMINAL) |=> !wrap);
endmodule

// File: rtl/art_duty.sv
module art_duty #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty_we,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             commit,
  output logic [CNT_W-1:0] act,
  output logic [CNT_W-1:0] act_nxt
);
  logic [CNT_W-1:0] pre_q, act_q;

  assign act_nxt = commit ? pre_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (duty_we) pre_q <= duty_wdata;
      if (commit)  act_q <= act_nxt;
    end
  end

  assign act = act_q;

  // R6: active duty changes only on a commit and takes the preload
  a_r6_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_q == $past(pre_q));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));
endmodule

// File: rtl/art_pwm_out.sv
module art_pwm_out #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] base_nxt,
  input  logic [CNT_W-1:0] act_nxt,
  output logic             pwm
);
  logic pwm_q, pwm_d;

  assign pwm_d = (cnt_nxt > base_nxt) && (cnt_nxt < act_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/art_pwm_timer.sv
module art_pwm_timer #(
  parameter int CNT_W   = 12,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm,
  output logic             ovf,
  output logic             force_pend
);
  import art_pkg::*;

  localparam logic [CNT_W-1:0] TERMINAL = {CNT_W{1'b1}};

  logic             rst_s_n;
  art_sel_e         sel;
  logic             reload_we, duty_we, force_req;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_nxt, base, base_nxt, act, act_nxt;
  logic             wrap;

  art_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign sel       = art_sel_e'(wr_sel);
  assign reload_we = wr_en && (sel == SEL_RELOAD);
  assign duty_we   = wr_en && (sel == SEL_DUTY);
  assign force_req = wr_en && (sel == SEL_FORCE);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)       reload_q <= '0;
    else if (reload_we) reload_q <= wr_data;
  end

  art_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .force_req(force_req),
    .reload(reload_q), .cnt(cnt), .cnt_nxt(cnt_nxt), .base(base),
    .base_nxt(base_nxt), .wrap(wrap), .pend(force_pend)
  );

  art_duty #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_s_n), .duty_we(duty_we), .duty_wdata(wr_data),
    .commit(wrap), .act(act), .act_nxt(act_nxt)
  );

  art_pwm_out #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst_n(rst_s_n), .cnt_nxt(cnt_nxt), .base_nxt(base_nxt),
    .act_nxt(act_nxt), .pwm(pwm)
  );

  assign ovf = wrap;

  // R7: output is low at the terminal count and right after a wrap
  a_r7_low_at_terminal: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cnt == TERMINAL) |-> !pwm);
  a_r7_low_after_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovf |=> !pwm);
  // R7: high output implies a duty above the period start
  a_r7_high_needs_room: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwm |-> (act > base) && (cnt < act));
  // R8: period start only moves on a wrap
  a_r8_base_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ovf |=> $stable(base));
endmodule

// File: tb/art_pwm_timer_bench.sv
module art_pwm_timer_bench;
  localparam int W = 12;
  localparam logic [W-1:0] TOP = 12'hFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd3;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic         pwm, ovf, force_pend;

  int n_chk = 0, n_fail = 0;
  logic         seen_ovf;
  logic [W-1:0] m_cnt, m_base, m_arr, m_pre, m_act;
  logic         m_pend, m_pwm;

  always #2 clk = ~clk;

  art_pwm_timer u_art_pwm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt(cnt), .pwm(pwm), .ovf(ovf), .force_pend(force_pend)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic we, input logic [1:0] s,
                      input logic [W-1:0] d);
    logic m_ovf;
    @(negedge clk);
    tick = t; wr_en = we; wr_sel = s; wr_data = d;
    #1;
    m_ovf = t && (m_cnt == TOP);
    seen_ovf = ovf;
    chk("R2 count", int'(cnt), int'(m_cnt));
    chk("R9 ovf", int'(ovf), int'(m_ovf));
    chk("R7 pwm", int'(pwm), int'(m_pwm));
    chk("R4 status", int'(force_pend), int'(m_pend));
    if (m_ovf) begin
      m_cnt = m_arr; m_base = m_arr; m_act = m_pre; m_pend = 1'b0;
    end else if (we && s == 2'd2) begin
      m_cnt = TOP; m_pend = 1'b1;
    end else if (t) begin
      m_cnt = m_cnt + 1'b1;
    end
    if (we && s == 2'd0) m_arr = d;
    if (we && s == 2'd1) m_pre = d;
    m_pwm = (m_cnt > m_base) && (m_cnt < m_act);
    @(posedge clk);
    #1;
    tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd3, '0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_cnt = '0; m_base = '0; m_arr = '0; m_pre = '0; m_act = '0;
    m_pend = 1'b0; m_pwm = 1'b0;
    #9 rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 count", int'(cnt), 0);
    chk("R1 pwm", int'(pwm), 0);
    chk("R1 status", int'(force_pend), 0);
    // R2 ticks advance, idle holds
    step(1, 0, 3, '0); step(1, 0, 3, '0); idle(2);
    chk("R2 two ticks", int'(cnt), 2);
    // R9 select 3 writes nothing
    step(0, 1, 3, 12'h123);
    chk("R9 sel3 no effect", int'(cnt), 2);
    // R4 force without tick
    step(0, 1, 2, 12'h055);
    chk("R4 terminal", int'(cnt), int'(TOP));
    chk("R4 status set", int'(force_pend), 1);
    idle(2);
    chk("R4 status held", int'(force_pend), 1);
    // R3/R1 overflow reloads reset reload value 0
    step(1, 0, 3, '0);
    chk("R3 ovf pulse", int'(seen_ovf), 1);
    chk("R3 reload zero", int'(cnt), 0);
    chk("R5 status clear", int'(force_pend), 0);
    // R8 reload write applies at next wrap only
    step(0, 1, 0, 12'hFF0);
    chk("R8 no immediate effect", int'(cnt), 0);
    step(0, 1, 1, 12'hFF8);
    step(0, 1, 2, '0);
    step(1, 0, 3, '0);
    chk("R8 reload used", int'(cnt), 12'hFF0);
    // R6 duty active now FF8; write new preload mid-period
    step(0, 1, 1, 12'hFFC);
    for (int i = 0; i < 10; i++) step(1, 0, 3, '0);
    chk("R6 old duty still active", int'(pwm), 0);
    for (int i = 0; i < 6; i++) step(1, 0, 3, '0);
    chk("R6 commit at wrap", int'(cnt), 12'hFF0);
    for (int i = 0; i < 10; i++) step(1, 0, 3, '0);
    chk("R6 new duty active", int'(pwm), 1);
    // R5 force coincident with overflow
    while (cnt != TOP) step(1, 0, 3, '0);
    step(1, 1, 2, '0);
    chk("R5 coincident ovf", int'(seen_ovf), 1);
    chk("R5 count reloaded", int'(cnt), 12'hFF0);
    chk("R5 status clear", int'(force_pend), 0);
    // Sweep: reload, duty, tick density, mid-period force
    for (int a = 0; a < 5; a++) begin
      logic [W-1:0] av;
      av = (a == 4) ? TOP : (12'hFF0 + 12'(a * 4));
      step(0, 1, 0, av);
      for (int dv = 12'hFEE; dv <= 12'hFFF; dv++) begin
        step(0, 1, 1, 12'(dv));
        step(0, 1, 2, '0);
        for (int i = 0; i < 40; i++) begin
          logic tk;
          tk = ((i + dv) % 3) != 0;
          if (i == 13 && (dv % 2) == 0) step(tk, 1, 2, '0);
          else step(tk, 0, 3, '0);
        end
      end
    end
    // R7 duty at or below start keeps output low for a full period
    step(0, 1, 0, 12'hFF4);
    step(0, 1, 1, 12'hFF4);
    step(0, 1, 2, '0);
    step(1, 0, 3, '0);
    step(1, 0, 3, '0);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 11; i++) begin
        step(1, 0, 3, '0);
        hi += int'(pwm);
      end
      chk("R7 low duty never high", hi, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule